// File: doc/BRIEF.md
# Reset Supervisor with Watchdog

This block generates an active-low system reset from a logic-level supply-good flag and a software watchdog strobe. While the supply-good flag is low, reset is asserted. When the flag rises, reset stays asserted for a fixed hold time and is then released. All timing comes from a one-cycle millisecond tick input. The hold length and the watchdog window are parameters given in ticks.

Once reset is released and the watchdog is enabled, software must toggle the strobe input. Either a rising or a falling edge counts as service. If a full window passes with no edge, the supervisor asserts reset for one hold time and then releases it. A fresh window then begins. This cycle repeats until the strobe is serviced, the supply flag drops, or the watchdog is disabled.

The strobe is an asynchronous pin and is brought into the clock domain through a synchronizer. The enable input takes the place of detecting a floating strobe pin. Every pin is a plain level signal, and there is no handshake at the block's edge.

Top module: `rst_supervisor`

## Requirements
- R1: A low on `pwr_ok` sampled at a clock edge drives `rst_out_n` low after that edge. It stays low for as long as `pwr_ok` is low, whatever the ticks, strobe or enable do.
- R2: After `pwr_ok` goes high, `rst_out_n` stays low through the first HOLD_MS-1 ticks. It goes high on the clock edge that samples the HOLD_MS-th tick.
- R3: Each rising edge and each falling edge on `wdi` restarts the watchdog window from zero. An edge takes effect three clock edges after the input changes (two synchronizer stages plus the previous-value register). Only ticks that arrive after that point count toward the window.
- R4: With `wdt_en` high and reset released, `rst_out_n` goes low on the edge that samples the WDT_MS-th tick with no strobe edge. Ticks are counted from release or from the last strobe edge.
- R5: While `wdt_en` is low, the watchdog window is held at zero and no watchdog reset occurs, whatever the number of ticks.
- R6: A watchdog expiry produces a reset pulse of exactly HOLD_MS ticks. After it, a full new window of WDT_MS ticks begins, and expiry repeats for as long as the strobe stays idle.
- R7: Lowering `wdt_en` while a watchdog reset pulse is in progress does not shorten or cancel that pulse. The pulse still completes its HOLD_MS ticks, and no further watchdog pulse follows.
- R8: While `rst_n` is low, `rst_out_n` is low and both timers are cleared. After `rst_n` is released, the hold time counts a full HOLD_MS ticks from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low module reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond; advances both timers |
| pwr_ok | input | 1 | Supply-good level, already qualified |
| wdt_en | input | 1 | Watchdog enable (low stands in for a floating strobe pin) |
| wdi | input | 1 | Watchdog strobe, asynchronous; either edge services |
| rst_out_n | output | 1 | Active-low system reset |

## Verification
The bench targets the edges of each count. It checks that the pulse ends on exactly the HOLD_MS-th tick and that the window expires on exactly the WDT_MS-th tick. A design off by one tick would release one tick early or late, and the checks one tick before and on the boundary would catch it. Two strobe cases are covered: a falling edge followed by a rising edge, which catches a design that reacts to only one edge polarity and so times out a window that software did service; and turning off the enable in the middle of a pulse, which catches a design that cuts the pulse short. Two restart cases are also covered: a supply dropout in the middle of the hold time, and a module reset in the middle of operation. Both must restart the hold time from zero, and a design that kept a stale count would release too soon.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  typedef enum logic {
    SV_HOLD = 1'b0,
    SV_RUN  = 1'b1
  } sv_state_e;
endpackage

// File: rtl/rsv_edge_det.sv
module rsv_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic toggled
);
  logic [STAGES-1:0] sh;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      prev <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-2:0], din};
      prev <= sh[STAGES-1];
    end
  end

  assign toggled = sh[STAGES-1] ^ prev;
endmodule

// File: rtl/rsv_ms_counter.sv
module rsv_ms_counter #(
  parameter int LIMIT = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic done
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  assign done = step && !clr && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr || done) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int HOLD_MS    = 200,
  parameter int WDT_MS     = 1600,
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic pwr_ok,
  input  logic wdt_en,
  input  logic wdi,
  output logic rst_out_n
);
  import rsv_pkg::*;

  sv_state_e state, state_nx;
  logic      strobe_edge;
  logic      hold_clr, hold_step, hold_done;
  logic      win_clr, win_step, win_done;

  rsv_edge_det #(.STAGES(SYNC_DEPTH)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .din     (wdi),
    .toggled (strobe_edge)
  );

  assign hold_clr  = !pwr_ok || (state != SV_HOLD);
  assign hold_step = ms_tick;

  rsv_ms_counter #(.LIMIT(HOLD_MS)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (hold_clr),
    .step  (hold_step),
    .done  (hold_done)
  );

  assign win_clr  = !pwr_ok || (state != SV_RUN) || !wdt_en || strobe_edge;
  assign win_step = ms_tick;

  rsv_ms_counter #(.LIMIT(WDT_MS)) u_window (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (win_clr),
    .step  (win_step),
    .done  (win_done)
  );

  always_comb begin
    state_nx = state;
    if (!pwr_ok) begin
      state_nx = SV_HOLD;
    end else begin
      case (state)
        SV_HOLD: if (hold_done) state_nx = SV_RUN;
        SV_RUN:  if (win_done)  state_nx = SV_HOLD;
        default: state_nx = SV_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SV_HOLD;
    else        state <= state_nx;
  end

  assign rst_out_n = (state == SV_RUN);
endmodule

// File: rtl/rst_supervisor_chk.sv
module rst_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic ms_tick,
  input logic pwr_ok,
  input logic wdt_en,
  input logic rst_out_n
);
  AST_PWR_LOW_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> !rst_out_n) else $error("supply low did not assert reset"); // R1

  AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |-> ($past(ms_tick) && $past(pwr_ok))) else $error("release without tick"); // R2

  AST_FALL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out_n) |-> (!$past(pwr_ok) || ($past(ms_tick) && $past(wdt_en)))) else $error("reset without cause"); // R4

  AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_out_n && !wdt_en && pwr_ok) |=> rst_out_n) else $error("watchdog reset while disabled"); // R5

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwr_ok) && !$past(ms_tick)) |-> $stable(rst_out_n)) else $error("output moved without tick"); // R6
endmodule

bind rst_supervisor rst_supervisor_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ms_tick   (ms_tick),
  .pwr_ok    (pwr_ok),
  .wdt_en    (wdt_en),
  .rst_out_n (rst_out_n)
);

// File: tb/tb_rst_supervisor.sv
module tb_rst_supervisor;
  localparam int HOLD = 5;
  localparam int WDT  = 12;

  localparam logic [2:0] OP_PWR = 3'd0;
  localparam logic [2:0] OP_EN  = 3'd1;
  localparam logic [2:0] OP_TOG = 3'd2;
  localparam logic [2:0] OP_TCK = 3'd3;

  // fields: [15:13] operation, [12:1] argument, [0] expected rst_out_n
  localparam int NV = 18;
  localparam logic [15:0] VEC [NV] = '{
    {OP_PWR, 12'd1,  1'b0},  // R2 hold begins
    {OP_TCK, 12'd4,  1'b0},  // R2 one tick short
    {OP_TCK, 12'd1,  1'b1},  // R2 release
    {OP_TCK, 12'd30, 1'b1},  // R5 disabled, no expiry
    {OP_EN,  12'd1,  1'b1},
    {OP_TCK, 12'd11, 1'b1},  // R4 one short of window
    {OP_TCK, 12'd1,  1'b0},  // R4 expiry
    {OP_TCK, 12'd4,  1'b0},  // R6 pulse length
    {OP_TCK, 12'd1,  1'b1},  // R6 pulse ends
    {OP_TCK, 12'd11, 1'b1},  // R6 fresh window
    {OP_TOG, 12'd0,  1'b1},  // R3 rising edge services
    {OP_TCK, 12'd11, 1'b1},  // R3 window restarted
    {OP_TCK, 12'd1,  1'b0},  // R6 expiry repeats
    {OP_EN,  12'd0,  1'b0},  // R7 disable during pulse
    {OP_TCK, 12'd5,  1'b1},  // R7 pulse completes
    {OP_TCK, 12'd40, 1'b1},  // R7 no further pulse
    {OP_PWR, 12'd0,  1'b0},  // R1 supply drop
    {OP_TCK, 12'd10, 1'b0}   // R1 held low
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 1'b0;
  logic pwr_ok = 1'b0;
  logic wdt_en = 1'b0;
  logic wdi = 1'b0;
  logic rst_out_n;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   finished = 1'b0;

  always #2 clk = ~clk;

  rst_supervisor #(.HOLD_MS(HOLD), .WDT_MS(WDT)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ms_tick   (ms_tick),
    .pwr_ok    (pwr_ok),
    .wdt_en    (wdt_en),
    .wdi       (wdi),
    .rst_out_n (rst_out_n)
  );

  task automatic check(input logic exp, input string req);
    n_chk++;
    if (rst_out_n !== exp) begin
      n_bad++;
      $display("FAIL %s: rst_out_n=%b expected %b", req, rst_out_n, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      ms_tick = 1'b1;
      @(negedge clk);
      ms_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic toggle_wdi();
    wdi = ~wdi;
    repeat (3) @(negedge clk);
  endtask

  task automatic set_pwr(input logic v);
    pwr_ok = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(1'b0, "R8 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    check(1'b0, "R8 after reset, supply low");

    for (int k = 0; k < NV; k++) begin
      case (VEC[k][15:13])
        OP_PWR: set_pwr(VEC[k][1]);
        OP_EN:  begin wdt_en = VEC[k][1]; @(negedge clk); end
        OP_TOG: toggle_wdi();
        default: ticks(int'(VEC[k][12:1]));
      endcase
      check(VEC[k][0], $sformatf("R1-table step %0d", k));
    end

    // R1 / R2: a dropout during the hold time restarts the count
    set_pwr(1'b1);
    ticks(3);
    set_pwr(1'b0);
    check(1'b0, "R1 dropout in hold");
    set_pwr(1'b1);
    ticks(4);
    check(1'b0, "R2 hold restarted from zero");
    ticks(1);
    check(1'b1, "R2 release after full hold");

    // R3: the falling edge also services
    wdt_en = 1'b1;
    @(negedge clk);
    ticks(8);
    toggle_wdi();
    ticks(8);
    toggle_wdi();
    ticks(11);
    check(1'b1, "R3 both edge polarities service");
    ticks(1);
    check(1'b0, "R4 expiry after last edge");

    // R8: module reset mid-run clears the hold count
    ticks(3);
    rst_n = 1'b0;
    @(negedge clk);
    check(1'b0, "R8 reset asserted");
    rst_n = 1'b1;
    @(negedge clk);
    ticks(4);
    check(1'b0, "R8 hold counts from zero");
    ticks(1);
    check(1'b1, "R8 release after full hold");

    // R1: supply drop while released
    set_pwr(1'b0);
    check(1'b0, "R1 drop while released");

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule